// File: doc/BRIEF.md
# Two-Level Interrupt Controller

This block gathers single-cycle event pulses from several functional groups and turns them into one host interrupt pin. Every event sets a sticky status bit inside its group. Each group folds its unmasked status bits into one group flag. The unmasked group flags together drive a registered interrupt output. The output's active level can be selected, and the output can be held idle while the device is in a low-power hibernate state.

The host talks to the block through a plain synchronous register port made of an address, a read strobe, a write strobe, write data and registered read data. It has no valid/ready handshake. A read strobe is accepted in the cycle it is high, and its data appears on `reg_rdata` after the next rising edge. `reg_rdata` then holds that value until the next read. To service an interrupt, the host first reads the group summary to find the source, then reads that group's status register, which also clears it.

Address map (byte-free word addresses):

| Address | Contents |
|---|---|
| 0 | control: bit 0 = polarity, bit 1 = hibernate override |
| 1 | group summary (read-only) |
| 2 | group mask |
| 3 | reads as 0 |
| 4+2g | status of group g |
| 5+2g | bit mask of group g |

Top module: `irq_ctrl_top`

## Requirements
- R1: An event pulse on bit b of group g sets status bit b of group g at the next rising edge. The bit stays 1 until the status register of group g (address 4+2g) is read.
- R2: A read of the status register of group g returns its bits one cycle later and clears every bit of that register. A second read with no new event returns 0.
- R3: When an event arrives in the same cycle as a clearing read of its register, the bit is 1 after that edge, and the next read returns it.
- R4: Bit g of the group summary (address 1) equals the OR of group g's status bits whose bit-mask bit is 0. Reading the summary clears nothing.
- R5: A status bit whose bit-mask bit (address 5+2g, bit b) is 1 still latches and reads back as 1, but it does not set its group's summary bit or the interrupt output.
- R6: A group whose group-mask bit (address 2, bit g) is 1 does not drive the interrupt output, while its summary bit still shows its state.
- R7: With the polarity bit (address 0, bit 0) at 0, `irq_out` is 0 when any unmasked group flag is set and 1 otherwise. With the polarity bit at 1, `irq_out` is 1 when an unmasked group flag is set and 0 otherwise.
- R8: While `hib_in` is 1 and the hibernate-override bit (address 0, bit 1) is 1, `irq_out` sits at its inactive level. With the override bit at 0, `hib_in` has no effect.
- R9: `irq_out` is a register. It reflects status, mask, control and `hib_in` one clock after they change.
- R10: Control and mask registers are read/write and reset to 0. Writes to status registers and to the summary are ignored.
- R11: After reset all status bits are 0 and `irq_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | asynchronous reset, active low |
| evt_in | input | NUM_GRP*GRP_W | event pulses, group g in bits [g*GRP_W +: GRP_W] |
| hib_in | input | 1 | hibernate state of the device |
| reg_addr | input | ADDR_W | register address |
| reg_rd | input | 1 | read strobe, one cycle per read |
| reg_wr | input | 1 | write strobe |
| reg_wdata | input | DATA_W | write data |
| reg_rdata | output | DATA_W | read data, valid from the edge after the strobe |
| irq_out | output | 1 | host interrupt pin |

## Verification
The bench builds the block with three groups of four bits, so every address fits in four bits and only twelve event sources exist. That small size lets the bench sweep every source bit against both states of its bit mask, both states of its group mask and both polarities. In each of those cases it computes the expected summary, status and pin level directly from the rules above. The small register count also allows full read-back of every writable register and of the ignored-write addresses, plus targeted runs for coincident events and the hibernate override.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_SUM   = 1;
  localparam int ADDR_GMASK = 2;
  localparam int ADDR_BASE  = 4;

  function automatic int stat_addr(input int g);
    return ADDR_BASE + 2 * g;
  endfunction

  function automatic int bmask_addr(input int g);
    return ADDR_BASE + 2 * g + 1;
  endfunction
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] evt_i,
  input  logic             clr_i,
  input  logic [GRP_W-1:0] bmask_i,
  output logic [GRP_W-1:0] status_o,
  output logic             flag_o
);
  logic [GRP_W-1:0] status_q;

  // a clearing read and a new event in one cycle: the event wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (clr_i ? '0 : status_q) | evt_i;
  end

  assign status_o = status_q;
  assign flag_o   = |(status_q & ~bmask_i);
endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int NUM_GRP = 4,
  parameter int GRP_W   = 8,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic                            reg_rd,
  input  logic                            reg_wr,
  input  logic [DATA_W-1:0]               reg_wdata,
  output logic [DATA_W-1:0]               reg_rdata,
  input  logic [NUM_GRP-1:0][GRP_W-1:0]   status_i,
  input  logic [NUM_GRP-1:0]              gflag_i,
  output logic [NUM_GRP-1:0][GRP_W-1:0]   bmask_o,
  output logic [NUM_GRP-1:0]              gmask_o,
  output logic                            pol_o,
  output logic                            hib_mode_o,
  output logic [NUM_GRP-1:0]              clr_o
);
  import irq_pkg::*;

  logic                          pol_q, hib_q;
  logic [NUM_GRP-1:0]            gmask_q;
  logic [NUM_GRP-1:0][GRP_W-1:0] bmask_q;
  logic [DATA_W-1:0]             rd_val, rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q   <= 1'b0;
      hib_q   <= 1'b0;
      gmask_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
        pol_q <= reg_wdata[0];
        hib_q <= reg_wdata[1];
      end
      if (reg_addr == ADDR_W'(ADDR_GMASK)) gmask_q <= reg_wdata[NUM_GRP-1:0];
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bmask_q[g] <= '0;
      else if (reg_wr && reg_addr == ADDR_W'(bmask_addr(g)))
        bmask_q[g] <= reg_wdata[GRP_W-1:0];
    end
    assign clr_o[g] = reg_rd && (reg_addr == ADDR_W'(stat_addr(g)));
  end

  always_comb begin
    rd_val = '0;
    if (reg_addr == ADDR_W'(ADDR_CTRL))  rd_val[1:0] = {hib_q, pol_q};
    if (reg_addr == ADDR_W'(ADDR_SUM))   rd_val[NUM_GRP-1:0] = gflag_i;
    if (reg_addr == ADDR_W'(ADDR_GMASK)) rd_val[NUM_GRP-1:0] = gmask_q;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (reg_addr == ADDR_W'(stat_addr(g)))  rd_val[GRP_W-1:0] = status_i[g];
      if (reg_addr == ADDR_W'(bmask_addr(g))) rd_val[GRP_W-1:0] = bmask_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_val;
  end

  assign reg_rdata  = rdata_q;
  assign bmask_o    = bmask_q;
  assign gmask_o    = gmask_q;
  assign pol_o      = pol_q;
  assign hib_mode_o = hib_q;
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int NUM_GRP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_GRP-1:0] gflag_i,
  input  logic [NUM_GRP-1:0] gmask_i,
  input  logic               pol_i,
  input  logic               hib_mode_i,
  input  logic               hib_i,
  output logic               irq_o
);
  logic active;
  logic irq_q;

  assign active = (|(gflag_i & ~gmask_i)) && !(hib_i && hib_mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b1;
    else        irq_q <= pol_i ? active : !active;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
  parameter int NUM_GRP = 4,
  parameter int GRP_W   = 8,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_GRP*GRP_W-1:0] evt_in,
  input  logic                     hib_in,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic                     reg_rd,
  input  logic                     reg_wr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  output logic                     irq_out
);
  logic [NUM_GRP-1:0][GRP_W-1:0] status_q;
  logic [NUM_GRP-1:0][GRP_W-1:0] bmask_q;
  logic [NUM_GRP-1:0]            clr, gflag, gmask_q;
  logic                          ctrl_pol, ctrl_hib;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_bank
    irq_status_bank #(.GRP_W(GRP_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt_in[g*GRP_W +: GRP_W]),
      .clr_i   (clr[g]),
      .bmask_i (bmask_q[g]),
      .status_o(status_q[g]),
      .flag_o  (gflag[g])
    );
  end

  irq_regs #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .status_i  (status_q),
    .gflag_i   (gflag),
    .bmask_o   (bmask_q),
    .gmask_o   (gmask_q),
    .pol_o     (ctrl_pol),
    .hib_mode_o(ctrl_hib),
    .clr_o     (clr)
  );

  irq_out_stage #(.NUM_GRP(NUM_GRP)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .gflag_i   (gflag),
    .gmask_i   (gmask_q),
    .pol_i     (ctrl_pol),
    .hib_mode_i(ctrl_hib),
    .hib_i     (hib_in),
    .irq_o     (irq_out)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NUM_GRP = 4,
  parameter int GRP_W   = 8,
  parameter int ADDR_W  = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_GRP*GRP_W-1:0]      evt_in,
  input logic                          hib_in,
  input logic                          reg_rd,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [NUM_GRP-1:0][GRP_W-1:0] status_q,
  input logic [NUM_GRP-1:0][GRP_W-1:0] bmask_q,
  input logic [NUM_GRP-1:0]            gmask_q,
  input logic                          ctrl_pol,
  input logic                          ctrl_hib,
  input logic                          irq_out
);
  import irq_pkg::*;

  // R3: every event bit is present in status after the edge, read or not
  assert_evt_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_in) |=> ((status_q & $past(evt_in)) == $past(evt_in)));

  // R8: hibernate override forces the inactive level
  assert_hib_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hib_in && ctrl_hib) |=> (irq_out == !$past(ctrl_pol)));

  // R6: all groups masked keeps the pin inactive
  assert_gmask_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&gmask_q) |=> (irq_out == !$past(ctrl_pol)));

  // R9: pin moves only after a change of its sources
  assert_out_registered_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(status_q) && $stable(bmask_q) && $stable(gmask_q) && $stable(ctrl_pol)
     && $stable(ctrl_hib) && $stable(hib_in)) |=> $stable(irq_out));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    // R2: read of a group status leaves only bits that arrived with it
    assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(stat_addr(g))) |=>
        ((status_q[g] & ~$past(evt_in[g*GRP_W +: GRP_W])) == '0));
    // R1: set bits hold while their register is not read
    assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd && reg_addr == ADDR_W'(stat_addr(g))) |=>
        ((status_q[g] & $past(status_q[g])) == $past(status_q[g])));
  end
endmodule

bind irq_ctrl_top irq_ctrl_chk #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt_in  (evt_in),
  .hib_in  (hib_in),
  .reg_rd  (reg_rd),
  .reg_addr(reg_addr),
  .status_q(status_q),
  .bmask_q (bmask_q),
  .gmask_q (gmask_q),
  .ctrl_pol(ctrl_pol),
  .ctrl_hib(ctrl_hib),
  .irq_out (irq_out)
);

// File: tb/sim_irq_ctrl_top.sv
module sim_irq_ctrl_top;
  localparam int NG = 3;
  localparam int GW = 4;
  localparam int DW = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NG*GW-1:0] evt_in = '0;
  logic          hib_in = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_rd = 1'b0;
  logic          reg_wr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_ctrl_top #(.NUM_GRP(NG), .GRP_W(GW), .DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .hib_in(hib_in),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = DW'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = AW'(a); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = int'(reg_rdata);
  endtask

  task automatic pulse(input int g, input int b);
    @(negedge clk);
    evt_in = '0; evt_in[g*GW + b] = 1'b1;
    @(negedge clk);
    evt_in = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin : stim
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(irq_out == 1'b1, "R11 pin after reset", irq_out, 1);
    for (int g = 0; g < NG; g++) begin
      rd(4 + 2*g, d); check(d == 0, "R11 status after reset", d, 0);
      rd(5 + 2*g, d); check(d == 0, "R10 bit mask reset", d, 0);
    end
    rd(0, d); check(d == 0, "R10 control reset", d, 0);
    rd(2, d); check(d == 0, "R10 group mask reset", d, 0);

    // R10 read/write and ignored writes
    for (int v = 0; v < 4; v++) begin
      wr(0, v); rd(0, d); check(d == v, "R10 control readback", d, v);
    end
    for (int v = 0; v < (1 << NG); v++) begin
      wr(2, v); rd(2, d); check(d == v, "R10 group mask readback", d, v);
    end
    for (int g = 0; g < NG; g++) begin
      wr(5 + 2*g, 4'hA ^ g); rd(5 + 2*g, d);
      check(d == (4'hA ^ g), "R10 bit mask readback", d, 4'hA ^ g);
      wr(5 + 2*g, 0);
      wr(4 + 2*g, 8'hFF); rd(4 + 2*g, d); check(d == 0, "R10 status write ignored", d, 0);
    end
    wr(0, 0); wr(2, 0);
    wr(1, 8'hFF); rd(1, d); check(d == 0, "R10 summary write ignored", d, 0);
    check(irq_out == 1'b1, "R10 pin idle after ignored writes", irq_out, 1);

    // sweep: every source x bit mask x group mask x polarity
    for (int pol = 0; pol < 2; pol++)
      for (int g = 0; g < NG; g++)
        for (int b = 0; b < GW; b++)
          for (int bm = 0; bm < 2; bm++)
            for (int gm = 0; gm < 2; gm++) begin
              automatic int act   = (bm == 0 && gm == 0) ? 1 : 0;
              automatic int idle  = pol ? 0 : 1;
              automatic int asrt  = pol ? 1 : 0;
              automatic int exp_o = act ? asrt : idle;
              wr(0, pol);
              wr(5 + 2*g, bm << b);
              wr(2, gm << g);
              @(negedge clk);
              check(irq_out == idle, "R7 pin idle before event", irq_out, idle);
              pulse(g, b);
              // status set at the edge inside pulse; pin one edge later (R9)
              check(irq_out == idle, "R9 pin not yet changed", irq_out, idle);
              @(negedge clk);
              check(irq_out == exp_o, act ? "R7 pin asserted" : "R5/R6 masked pin idle",
                    irq_out, exp_o);
              rd(1, d); check(d == ((bm ? 0 : 1) << g), "R4 summary", d, (bm ? 0 : 1) << g);
              rd(1, d); check(d == ((bm ? 0 : 1) << g), "R4 summary not cleared", d,
                              (bm ? 0 : 1) << g);
              rd(4 + 2*g, d); check(d == (1 << b), "R1 R5 status latched", d, 1 << b);
              rd(4 + 2*g, d); check(d == 0, "R2 status cleared", d, 0);
              @(negedge clk);
              check(irq_out == idle, "R2 pin idle after clear", irq_out, idle);
              wr(5 + 2*g, 0); wr(2, 0); wr(0, 0);
            end

    // R3 event coincident with clearing read
    for (int g = 0; g < NG; g++) begin
      pulse(g, 1);
      @(negedge clk);
      reg_addr = AW'(4 + 2*g); reg_rd = 1'b1; evt_in[g*GW + 1] = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0; evt_in = '0; d = int'(reg_rdata);
      check(d == 2, "R3 read returns prior bit", d, 2);
      rd(4 + 2*g, d); check(d == 2, "R3 coincident event kept", d, 2);
      rd(4 + 2*g, d); check(d == 0, "R3 cleared afterwards", d, 0);
    end

    // R8 hibernate override
    for (int pol = 0; pol < 2; pol++) begin
      automatic int idle = pol ? 0 : 1;
      wr(0, 2 | pol);
      hib_in = 1'b1;
      pulse(0, 0);
      @(negedge clk);
      check(irq_out == idle, "R8 forced idle", irq_out, idle);
      hib_in = 1'b0;
      @(negedge clk);
      check(irq_out == !idle, "R8 released", irq_out, !idle);
      wr(0, pol);
      hib_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(irq_out == !idle, "R8 override off, hib ignored", irq_out, !idle);
      hib_in = 1'b0;
      rd(4, d);
      wr(0, 0);
    end

    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule